// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block adds two unsigned binary words and a carry bit in a single combinational pass. Every bit position first works out two flags. One flag says that the bit makes a carry by itself. The other says that the bit would pass an incoming carry upward. The operand word is split into fixed-size slices. Inside each slice, each carry is built straight from those flags and the carry entering the slice, as one OR of AND terms. No carry depends on the carry of its neighbour inside the slice.

The slices are linked in a chain. The carry leaving one slice is the carry entering the next. The carry leaving the top slice is the adder's carry output. Each sum bit is the bit's propagate flag XORed with the carry that reaches it.

The word width and the slice width are parameters. The defaults are 32 bits in slices of 4. There is no clock, no register and no control input, so the block can be placed inside any datapath stage.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of `op_a + op_b + carry_in`, taken as unsigned numbers.
- R2: `carry_out` equals bit WIDTH of the (WIDTH+1)-bit unsigned total `op_a + op_b + carry_in`.
- R3: For each bit i, generate is `op_a[i] & op_b[i]` and propagate is `op_a[i] ^ op_b[i]`. The two are never both 1 in the same bit.
- R4: Inside a slice, each carry is a direct sum of products of the generate and propagate flags and the slice's entry carry. The result obeys c[i+1] = g[i] | (p[i] & c[i]) at every position.
- R5: Slices are GROUP_W = 4 bits wide. Slice 0 takes `carry_in`, and each later slice takes the carry leaving the slice below it. A carry made in bit 0 therefore reaches bit WIDTH-1 and `carry_out` when all higher bits propagate.
- R6: When every bit propagates (`op_a ^ op_b` all ones), `carry_out` equals `carry_in`, and `sum` is all ones for `carry_in` = 0 and all zeros for `carry_in` = 1.
- R7: Adding all-ones to all-ones gives `sum` = all ones except bit 0 equal to `carry_in`, and `carry_out` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry out of the most significant slice |

## Verification
The bench aims at carries that must cross slice boundaries. Examples are 0x0000000F + 1, all-ones + 1, and full-propagate words with each entry carry. A design that broke the slice-to-slice link, or dropped the all-propagate product term, would return a sum with a wrong upper nibble, or a carry output stuck at 0. An 8-bit instance is swept over every operand pair and entry carry. This exposes any missing or misordered product term in the flattened carry expressions, because every generate and propagate combination in a slice is applied. Alternating patterns and random 32-bit words then cover the default size.

// File: rtl/cla_pkg.sv
package cla_pkg;
  parameter int unsigned CLA_WIDTH_DEFAULT = 32;
  parameter int unsigned CLA_GROUP_DEFAULT = 4;
endpackage

// File: rtl/cla_pg.sv
module cla_pg #(
  parameter int unsigned WIDTH = cla_pkg::CLA_WIDTH_DEFAULT
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] prop
);
  always_comb begin
    gen  = op_a & op_b;
    prop = op_a ^ op_b;
  end

  // A bit cannot both create and pass a carry.
  always_comb begin
    assert_gp_exclusive_R3: assert ((gen & prop) == '0)
      else $error("generate and propagate overlap");
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned GROUP_W = cla_pkg::CLA_GROUP_DEFAULT
) (
  input  logic [GROUP_W-1:0] gen,
  input  logic [GROUP_W-1:0] prop,
  input  logic               cin,
  output logic [GROUP_W-1:0] carries,
  output logic               cout
);
  logic [GROUP_W:0] c;

  // Flattened sum of products: c[i] built only from g, p and cin.
  always_comb begin
    logic term;
    logic acc;
    c    = '0;
    c[0] = cin;
    for (int i = 1; i <= GROUP_W; i++) begin
      acc = 1'b0;
      for (int j = 0; j < i; j++) begin
        term = gen[j];
        for (int k = j + 1; k < i; k++) term = term & prop[k];
        acc = acc | term;
      end
      term = cin;
      for (int k = 0; k < i; k++) term = term & prop[k];
      acc  = acc | term;
      c[i] = acc;
    end
  end

  always_comb begin
    carries = c[GROUP_W-1:0];
    cout    = c[GROUP_W];
  end

  // The flattened terms must agree with the bit-serial recurrence.
  always_comb begin
    for (int i = 0; i < GROUP_W; i++) begin
      assert_carry_recurrence_R4: assert (c[i+1] == (gen[i] | (prop[i] & c[i])))
        else $error("group carry %0d breaks recurrence", i + 1);
    end
  end
endmodule

// File: rtl/cla_sum.sv
module cla_sum #(
  parameter int unsigned WIDTH = cla_pkg::CLA_WIDTH_DEFAULT
) (
  input  logic [WIDTH-1:0] prop,
  input  logic [WIDTH-1:0] carries,
  output logic [WIDTH-1:0] sum
);
  always_comb sum = prop ^ carries;
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int unsigned WIDTH   = cla_pkg::CLA_WIDTH_DEFAULT,
  parameter int unsigned GROUP_W = cla_pkg::CLA_GROUP_DEFAULT
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  localparam int unsigned NUM_GROUPS = WIDTH / GROUP_W;

  logic [WIDTH-1:0]    gen;
  logic [WIDTH-1:0]    prop;
  logic [WIDTH-1:0]    bit_c;
  logic [NUM_GROUPS:0] grp_c;

  cla_pg #(.WIDTH(WIDTH)) u_pg (
    .op_a (op_a),
    .op_b (op_b),
    .gen  (gen),
    .prop (prop)
  );

  assign grp_c[0] = carry_in;

  for (genvar gi = 0; gi < NUM_GROUPS; gi++) begin : g_slice
    cla_group #(.GROUP_W(GROUP_W)) u_grp (
      .gen     (gen[gi*GROUP_W +: GROUP_W]),
      .prop    (prop[gi*GROUP_W +: GROUP_W]),
      .cin     (grp_c[gi]),
      .carries (bit_c[gi*GROUP_W +: GROUP_W]),
      .cout    (grp_c[gi+1])
    );
  end

  cla_sum #(.WIDTH(WIDTH)) u_sum (
    .prop    (prop),
    .carries (bit_c),
    .sum     (sum)
  );

  assign carry_out = grp_c[NUM_GROUPS];

  // Whole-word arithmetic checks against the slice network.
  logic [WIDTH:0] ref_total;
  always_comb begin
    ref_total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    assert_sum_value_R1: assert (sum == ref_total[WIDTH-1:0])
      else $error("sum mismatch");
    assert_carry_out_R2: assert (carry_out == ref_total[WIDTH])
      else $error("carry_out mismatch");
    if (&prop) begin
      assert_full_propagate_R6: assert (carry_out == carry_in)
        else $error("propagate chain broken");
    end
  end
endmodule

// File: tb/test_cla_adder.sv
module test_cla_adder;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] a32, b32, s32;
  logic        ci32, co32;
  logic [7:0]  a8, b8, s8;
  logic        ci8, co8;

  cla_adder i_cla_adder (
    .op_a(a32), .op_b(b32), .carry_in(ci32), .sum(s32), .carry_out(co32)
  );

  cla_adder #(.WIDTH(8), .GROUP_W(4)) i_cla_adder_small (
    .op_a(a8), .op_b(b8), .carry_in(ci8), .sum(s8), .carry_out(co8)
  );

  task automatic chk32(input logic [31:0] a, input logic [31:0] b,
                       input logic ci, input string tag);
    logic [32:0] exp;
    @(negedge clk);
    a32 = a; b32 = b; ci32 = ci;
    #2;
    exp = {1'b0, a} + {1'b0, b} + {32'd0, ci};
    checks++;
    if (s32 !== exp[31:0]) begin
      errors++;
      $display("FAIL R1 %s a=%h b=%h ci=%b sum actual=%h expected=%h",
               tag, a, b, ci, s32, exp[31:0]);
    end
    checks++;
    if (co32 !== exp[32]) begin
      errors++;
      $display("FAIL R2 %s a=%h b=%h ci=%b carry actual=%b expected=%b",
               tag, a, b, ci, co32, exp[32]);
    end
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    a32 = '0; b32 = '0; ci32 = 1'b0;
    a8 = '0; b8 = '0; ci8 = 1'b0;
    // Idle state: zero operands
    chk32(32'h0, 32'h0, 1'b0, "R1 zero");
    chk32(32'h0, 32'h0, 1'b1, "R2 zero+cin");
    // R3: pure propagate vs pure generate patterns
    chk32(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R3 R6 alt prop cin0");
    chk32(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R3 R6 alt prop cin1");
    chk32(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, "R3 alt gen");
    chk32(32'h5555_5555, 32'h5555_5555, 1'b1, "R3 alt gen cin");
    // R4: carries inside one slice
    chk32(32'h0000_0007, 32'h0000_0001, 1'b0, "R4 in-slice");
    chk32(32'h0000_0006, 32'h0000_0001, 1'b1, "R4 cin in-slice");
    // R5: carries crossing slice boundaries
    chk32(32'h0000_000F, 32'h0000_0001, 1'b0, "R5 one boundary");
    chk32(32'h0FFF_FFFF, 32'h0000_0000, 1'b1, "R5 seven boundaries");
    chk32(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R5 full chain");
    // R6: full propagate
    chk32(32'hFFFF_FFFF, 32'h0000_0000, 1'b0, "R6 prop cin0");
    chk32(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R6 prop cin1");
    chk32(32'h1234_5678, 32'hEDCB_A987, 1'b1, "R6 mixed prop");
    // R7: all ones plus all ones
    chk32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R7 ones cin0");
    chk32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R7 ones cin1");
    // Random 32-bit vectors
    for (int n = 0; n < 2000; n++) begin
      chk32($urandom, $urandom, 1'($urandom), "R1 R2 random");
    end
    // Exhaustive sweep of the 8-bit configuration (R4, R5 every pattern)
    for (int c = 0; c < 2; c++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          logic [8:0] exp8;
          @(negedge clk);
          a8 = 8'(x); b8 = 8'(y); ci8 = 1'(c);
          #2;
          exp8 = 9'(x) + 9'(y) + 9'(c);
          checks++;
          if ({co8, s8} !== exp8) begin
            errors++;
            $display("FAIL R4/R5 sweep a=%h b=%h ci=%0d actual=%h expected=%h",
                     a8, b8, c, {co8, s8}, exp8);
          end
        end
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule